// File: doc/BRIEF.md
# Memory Refresh Request Generator

This block keeps dynamic or pseudo-static memory alive by asking the bus controller for a refresh cycle at a fixed, programmable spacing. A down-counter measures the spacing in clocks. Each time it runs out, a request is raised. The request stays up until the bus controller acknowledges it. The bus controller then runs a memory read cycle at the address this block presents.

The refresh address has two parts. The low part is a row counter that moves forward by one after every acknowledged refresh. The high part is a programmable block number, so the refreshed window can start on any 8 KB boundary. Address bit 0 and the high-byte enable are both held high. That byte-enable pattern marks the bus cycle as a refresh and not an ordinary access.

Software configures the block through a small register write port with three registers: block base, interval and control. Their current values appear on read-back outputs.

Top module: `rfsh_refresh_gen`

## Requirements
- R1: While reset is high, and after it, the block sits idle: no request, row counter 0, base 0, interval 0, enable 0.
- R2: A write with `reg_sel` = 0 loads the base from `reg_wdata[6:0]`. Select 1 loads the interval from `reg_wdata[8:0]`. Select 2 loads the enable from `reg_wdata[0]`. Select 3 changes nothing. Each value appears on its read-back port after the write edge.
- R3: Let the enable be written while the interval N (N >= 2) is already set. `rfsh_req` then rises exactly N clocks after the enabling edge. After that, expiries come every N clocks.
- R4: A raised request stays high until it is acknowledged.
- R5: An acknowledge seen while the request is high advances the 12-bit row counter by one, and the counter wraps from 4095 to 0.
- R6: An acknowledge while no request is pending leaves the row counter and the request unchanged.
- R7: `rfsh_addr[19:13]` carries the base and `rfsh_addr[12:1]` carries the row counter. `rfsh_addr[0]` and `rfsh_bhe` are both 1, which marks the cycle as a refresh.
- R8: Clearing the enable drops a pending request within one clock and stops further requests.
- R9: An interval of 0 or 1 counts as disabled: no request is raised and any pending request is dropped.
- R10: If an expiry falls on the same edge as an acknowledge, the request stays high (a new one is pending) and the row still advances.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 base, 1 interval, 2 control, 3 none |
| reg_wdata | input | 16 | Register write data |
| rfsh_ack | input | 1 | Bus controller has run the refresh cycle |
| rfsh_req | output | 1 | Refresh request pending |
| rfsh_addr | output | 20 | Refresh address: base, row counter, bit 0 high |
| rfsh_bhe | output | 1 | High-byte enable, held high as the refresh marker |
| cfg_base | output | 7 | Read-back of the block base |
| cfg_interval | output | 9 | Read-back of the interval |
| cfg_enable | output | 1 | Read-back of the enable |

## Verification
The row counter's wrap from 4095 to 0 only shows up after 4096 acknowledged refreshes. The bench reaches it by setting the shortest legal interval and acknowledging each request as soon as it appears, checking the row at every step. The coincidence of an expiry with an acknowledge needs the acknowledge held back by exactly one clock at interval 2, so that it lands on the next expiry edge. The bench also sweeps every interval from 2 to 17 and every base value.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    localparam int unsigned DEF_ROW_W  = 12;
    localparam int unsigned DEF_BASE_W = 7;
    localparam int unsigned DEF_CNT_W  = 9;
    localparam int unsigned DEF_DATA_W = 16;

    // Intervals below this value are treated as disabled.
    localparam int unsigned MIN_INTERVAL = 2;

    typedef enum logic [1:0] {
        SEL_BASE = 2'd0,
        SEL_IVAL = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // Bit of the control register that gates the interval counter.
    localparam int unsigned CTRL_EN_BIT = 0;

endpackage

// File: rtl/rfsh_cfg_regs.sv
module rfsh_cfg_regs
    import rfsh_pkg::*;
#(
    parameter int unsigned BASE_W = DEF_BASE_W,
    parameter int unsigned CNT_W  = DEF_CNT_W,
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [BASE_W-1:0] base,
    output logic [CNT_W-1:0]  ival,
    output logic              en
);

    reg_sel_e sel_e;
    assign sel_e = reg_sel_e'(sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            base <= '0;
            ival <= '0;
            en   <= 1'b0;
        end else if (we) begin
            case (sel_e)
                SEL_BASE: base <= wdata[BASE_W-1:0];
                SEL_IVAL: ival <= wdata[CNT_W-1:0];
                SEL_CTRL: en   <= wdata[CTRL_EN_BIT];
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
    parameter int unsigned CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic [CNT_W-1:0] ival,
    output logic             expire
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // The last clock of each interval is the one where the count reads 1.
    assign expire = active && (cnt_q <= ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!active || (cnt_q <= ONE)) begin
            cnt_q <= ival;
        end else begin
            cnt_q <= cnt_q - ONE;
        end
    end

endmodule

// File: rtl/rfsh_row_tracker.sv
module rfsh_row_tracker #(
    parameter int unsigned ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             expire,
    input  logic             ack,
    output logic             pending,
    output logic [ROW_W-1:0] row
);

    logic grant;
    assign grant = pending && ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
        end else if (!active) begin
            pending <= 1'b0;
        end else if (expire) begin
            pending <= 1'b1;
        end else if (ack) begin
            pending <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            row <= '0;
        end else if (grant) begin
            row <= row + ROW_W'(1);
        end
    end

endmodule

// File: rtl/rfsh_refresh_gen.sv
module rfsh_refresh_gen
    import rfsh_pkg::*;
#(
    parameter int unsigned ROW_W  = DEF_ROW_W,
    parameter int unsigned BASE_W = DEF_BASE_W,
    parameter int unsigned CNT_W  = DEF_CNT_W,
    parameter int unsigned DATA_W = DEF_DATA_W,
    localparam int unsigned ADDR_W = BASE_W + ROW_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              rfsh_ack,
    output logic              rfsh_req,
    output logic [ADDR_W-1:0] rfsh_addr,
    output logic              rfsh_bhe,
    output logic [BASE_W-1:0] cfg_base,
    output logic [CNT_W-1:0]  cfg_interval,
    output logic              cfg_enable
);

    logic             active;
    logic             expire;
    logic [ROW_W-1:0] row;

    rfsh_cfg_regs #(
        .BASE_W (BASE_W),
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W)
    ) cfg_i (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .sel   (reg_sel),
        .wdata (reg_wdata),
        .base  (cfg_base),
        .ival  (cfg_interval),
        .en    (cfg_enable)
    );

    assign active = cfg_enable && (cfg_interval >= CNT_W'(MIN_INTERVAL));

    rfsh_interval_timer #(
        .CNT_W (CNT_W)
    ) timer_i (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .ival   (cfg_interval),
        .expire (expire)
    );

    rfsh_row_tracker #(
        .ROW_W (ROW_W)
    ) rows_i (
        .clk     (clk),
        .rst     (rst),
        .active  (active),
        .expire  (expire),
        .ack     (rfsh_ack),
        .pending (rfsh_req),
        .row     (row)
    );

    // Address bit 0 and the high-byte enable both high flag a refresh cycle.
    assign rfsh_addr = {cfg_base, row, 1'b1};
    assign rfsh_bhe  = 1'b1;

endmodule

// File: rtl/rfsh_refresh_gen_chk.sv
module rfsh_refresh_gen_chk #(
    parameter int unsigned ROW_W  = 12,
    parameter int unsigned BASE_W = 7,
    parameter int unsigned CNT_W  = 9,
    parameter int unsigned DATA_W = 16,
    localparam int unsigned ADDR_W = BASE_W + ROW_W + 1
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic [1:0]        reg_sel,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              rfsh_ack,
    input logic              rfsh_req,
    input logic [ADDR_W-1:0] rfsh_addr,
    input logic              rfsh_bhe,
    input logic [BASE_W-1:0] cfg_base,
    input logic [CNT_W-1:0]  cfg_interval,
    input logic              cfg_enable
);

    logic [ROW_W-1:0] row_v;
    assign row_v = rfsh_addr[ROW_W:1];

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!rfsh_req && row_v == '0 && !cfg_enable));

    p_pending_held_r4: assert property (@(posedge clk) disable iff (rst)
        (rfsh_req && !rfsh_ack && cfg_enable && cfg_interval >= CNT_W'(2)) |=> rfsh_req);

    p_row_step_r5: assert property (@(posedge clk) disable iff (rst)
        (rfsh_req && rfsh_ack) |=> (row_v == $past(row_v) + ROW_W'(1)));

    p_row_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !(rfsh_req && rfsh_ack) |=> $stable(row_v));

    p_disable_drop_r8: assert property (@(posedge clk) disable iff (rst)
        !cfg_enable |=> !rfsh_req);

    p_short_ival_r9: assert property (@(posedge clk) disable iff (rst)
        (cfg_interval < CNT_W'(2)) |=> !rfsh_req);

    p_marker_r7: assert property (@(posedge clk) disable iff (rst)
        rfsh_req |-> (rfsh_addr[0] && rfsh_bhe));

endmodule

bind rfsh_refresh_gen rfsh_refresh_gen_chk #(
    .ROW_W  (ROW_W),
    .BASE_W (BASE_W),
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W)
) chk_i (.*);

// File: tb/rfsh_refresh_gen_tb_top.sv
`timescale 1ns/1ps
module rfsh_refresh_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic        rfsh_ack = 1'b0;
    logic        rfsh_req;
    logic [19:0] rfsh_addr;
    logic        rfsh_bhe;
    logic [6:0]  cfg_base;
    logic [8:0]  cfg_interval;
    logic        cfg_enable;

    int checks = 0;
    int errors = 0;
    logic [11:0] exp_row = 12'd0;

    always #4 clk = ~clk;

    rfsh_refresh_gen dut_i (
        .clk          (clk),
        .rst          (rst),
        .reg_we       (reg_we),
        .reg_sel      (reg_sel),
        .reg_wdata    (reg_wdata),
        .rfsh_ack     (rfsh_ack),
        .rfsh_req     (rfsh_req),
        .rfsh_addr    (rfsh_addr),
        .rfsh_bhe     (rfsh_bhe),
        .cfg_base     (cfg_base),
        .cfg_interval (cfg_interval),
        .cfg_enable   (cfg_enable)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wait_rise(output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!rfsh_req);
    endtask

    // Acknowledge at the current negedge, then count clocks to the next request.
    task automatic ack_and_count(output int k);
        rfsh_ack = 1'b1;
        exp_row = exp_row + 12'd1;
        @(negedge clk);
        rfsh_ack = 1'b0;
        check(rfsh_addr[12:1] == exp_row, "R5 row after ack", rfsh_addr[12:1], exp_row);
        k = 1;
        while (!rfsh_req) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic ack_now();
        while (!rfsh_req) @(negedge clk);
        rfsh_ack = 1'b1;
        exp_row = exp_row + 12'd1;
        @(negedge clk);
        rfsh_ack = 1'b0;
        check(rfsh_addr[12:1] == exp_row, "R5 row step", rfsh_addr[12:1], exp_row);
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int k;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!rfsh_req, "R1 req", rfsh_req, 0);
        check(rfsh_addr == 20'h00001, "R1 addr", rfsh_addr, 1);
        check(!cfg_enable && cfg_base == 0 && cfg_interval == 0, "R1 cfg", cfg_interval, 0);
        rst = 1'b0;
        @(negedge clk);

        // R2 select 3 writes nothing
        wr(2'd3, 16'hFFFF);
        check(cfg_base == 0 && cfg_interval == 0 && !cfg_enable, "R2 sel3 ignored",
              {cfg_enable, cfg_interval, cfg_base}, 0);

        // R2/R7 base sweep
        for (int b = 0; b < 128; b++) begin
            wr(2'd0, 16'(b) | 16'hFF80);
            check(cfg_base == 7'(b), "R2 base readback", cfg_base, b);
            check(rfsh_addr[19:13] == 7'(b) && rfsh_addr[0] && rfsh_bhe, "R7 address layout",
                  rfsh_addr, {b[6:0], 13'h0001});
        end
        wr(2'd0, 16'h0055);
        wr(2'd1, 16'hFE05);
        check(cfg_interval == 9'h005, "R2 interval readback", cfg_interval, 5);
        wr(2'd1, 16'h0000);

        // R3 interval sweep with period measurement
        for (int n = 2; n < 18; n++) begin
            wr(2'd1, 16'(n));
            wr(2'd2, 16'h0001);
            check(cfg_enable, "R2 enable readback", cfg_enable, 1);
            wait_rise(k);
            check(k == n, "R3 first request delay", k, n);
            check(rfsh_addr == {7'h55, exp_row, 1'b1} && rfsh_bhe, "R7 addr on request",
                  rfsh_addr, {7'h55, exp_row, 1'b1});
            ack_and_count(k);
            check(k == n, "R3 period", k, n);
            ack_and_count(k);
            check(k == n, "R3 period repeat", k, n);
            // R4 hold without ack
            repeat (2 * n + 1) begin
                @(negedge clk);
                check(rfsh_req, "R4 held until ack", rfsh_req, 1);
            end
            // R8 disable drops pending
            wr(2'd2, 16'h0000);
            @(negedge clk);
            check(!rfsh_req, "R8 dropped on disable", rfsh_req, 0);
            repeat (3 * n) begin
                @(negedge clk);
                if (rfsh_req) check(0, "R8 no request while disabled", 1, 0);
            end
            check(rfsh_addr[12:1] == exp_row, "R8 row unchanged", rfsh_addr[12:1], exp_row);
        end

        // R10 expiry on the ack edge, interval 2
        wr(2'd1, 16'd2);
        wr(2'd2, 16'h0001);
        wait_rise(k);
        @(negedge clk);
        rfsh_ack = 1'b1;
        exp_row = exp_row + 12'd1;
        @(negedge clk);
        rfsh_ack = 1'b0;
        check(rfsh_req, "R10 request stays set", rfsh_req, 1);
        check(rfsh_addr[12:1] == exp_row, "R10 row advanced", rfsh_addr[12:1], exp_row);
        wr(2'd2, 16'h0000);

        // R9 short intervals count as disabled
        for (int v = 0; v < 2; v++) begin
            wr(2'd1, 16'(v));
            wr(2'd2, 16'h0001);
            k = 0;
            repeat (40) begin
                @(negedge clk);
                if (rfsh_req) k++;
            end
            check(k == 0, "R9 no request for short interval", k, 0);
            wr(2'd2, 16'h0000);
        end

        // R6 ack with nothing pending
        wr(2'd1, 16'd20);
        wr(2'd2, 16'h0001);
        @(negedge clk);
        rfsh_ack = 1'b1;
        @(negedge clk);
        rfsh_ack = 1'b0;
        @(negedge clk);
        check(!rfsh_req, "R6 req unaffected", rfsh_req, 0);
        check(rfsh_addr[12:1] == exp_row, "R6 row unaffected", rfsh_addr[12:1], exp_row);
        wr(2'd2, 16'h0000);

        // R5 wrap of the row counter
        wr(2'd1, 16'd2);
        wr(2'd2, 16'h0001);
        while (exp_row != 12'hFFF) ack_now();
        check(rfsh_addr[12:1] == 12'hFFF, "R5 row at top", rfsh_addr[12:1], 4095);
        ack_now();
        check(rfsh_addr[12:1] == 12'h000, "R5 row wrapped", rfsh_addr[12:1], 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule